// File: doc/BRIEF.md
# Permission-Checked Translation Cache

This block is a small, fully associative cache of page translations placed in front of a page table walker. A requester presents a virtual page number, says whether the access is a write, and says whether it runs in supervisor mode. In the same cycle the block answers with one of three results: a hit carrying the physical frame number, a miss telling the requester to walk the page table, or a protection fault. The fault result is reported separately from a miss, so a write to a read-only shared page can be told apart from an absent page. This is what lets software implement copy-on-write.

Each cached entry holds a tag, a frame number and three permission bits: supervisor-only, readable and writable. After a walk, the fill port loads a complete entry. The invalidate port removes one entry, selected by page number, or clears the whole cache. On a fill, the block first reuses an entry that already holds the same page. If there is none, it takes the lowest free slot. If the cache is full, it takes the slot chosen by a round-robin victim pointer.

Top module: `xcache_top`

## Requirements
- R1: After reset every entry is invalid, and any lookup reports a miss.
- R2: A lookup of a cached page whose permissions allow the access asserts hit and drives that entry's frame number in the same cycle.
- R3: A lookup whose page matches no valid entry asserts miss. Whenever hit is low, frameOut is zero.
- R4: A write to a cached page whose writable bit is 0 asserts fault and not hit.
- R5: A read of a cached page whose readable bit is 0 asserts fault and not hit.
- R6: A user-mode access (lookupSuper = 0) to a cached page whose supervisor-only bit is 1 asserts fault. The same access in supervisor mode hits.
- R7: At most one of hit, miss and fault is high at any time. All three are low while lookupValid is low.
- R8: A fill whose page matches a valid entry overwrites that entry, so no second copy of the page exists.
- R9: A fill of a new page uses the lowest-numbered invalid entry if any entry is invalid.
- R10: When all entries are valid, a fill of a new page replaces the entry at the victim pointer. The pointer starts at 0 after reset, advances by one only on such replacements, and wraps from the last entry to 0.
- R11: A single invalidate removes only the entry whose page equals invPage, effective from the next cycle.
- R12: A flush (invValid with invAll = 1) makes every entry invalid from the next cycle.
- R13: When invValid and fillValid are high in the same cycle, the invalidate is applied and the fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | A lookup is presented this cycle |
| lookupPage | input | TAG_W | Virtual page number to translate |
| lookupWrite | input | 1 | 1 = write access, 0 = read access |
| lookupSuper | input | 1 | 1 = requester is in supervisor mode |
| hit | output | 1 | Translation found and permitted |
| miss | output | 1 | No valid entry for the page |
| fault | output | 1 | Entry found but the access is not permitted |
| frameOut | output | FRAME_W | Physical frame number on a hit, zero otherwise |
| fillValid | input | 1 | Load an entry at the next edge |
| fillPage | input | TAG_W | Page number of the entry being loaded |
| fillFrame | input | FRAME_W | Frame number of the entry being loaded |
| fillSupOnly | input | 1 | Supervisor-only bit of the new entry |
| fillCanRead | input | 1 | Readable bit of the new entry |
| fillCanWrite | input | 1 | Writable bit of the new entry |
| invValid | input | 1 | Invalidate request |
| invAll | input | 1 | 1 = flush every entry, 0 = only the entry matching invPage |
| invPage | input | TAG_W | Page number to invalidate |

## Verification
The bench probes each way a permission can be refused, one at a time, and then confirms that the same page still hits when the access is allowed. A design that folded faults into misses, or that ignored the supervisor bit, would return a miss or a hit where the bench expects a fault. Refilling an already cached page with a new frame and then invalidating it exposes a design that creates duplicates: the stale copy would keep hitting. A full-cache sequence mixes a free slot left by a single invalidate with several evictions and one pointer wrap. A design that ignored free slots, advanced the pointer on every fill, or failed to wrap would evict a different page than expected, and a later lookup of that page would hit or miss wrongly. A fill issued together with a flush checks the collision rule.

// File: rtl/xcache_pkg.sv
`timescale 1ns/1ps
package xcache_pkg;

  // Permission bits cached with every translation
  typedef struct packed {
    logic supOnly;
    logic canRead;
    logic canWrite;
  } permBits_t;

  // Strobes from control to datapath for one clock edge
  typedef struct packed {
    logic fillEn;
    logic flushAll;
    logic dropOne;
  } ctrlStrobe_t;

endpackage

// File: rtl/xcache_datapath.sv
`timescale 1ns/1ps
module xcache_datapath
  import xcache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [ENTRIES-1:0] wrSel,
  input  logic               lookupValid,
  input  logic [TAG_W-1:0]   lookupPage,
  input  logic               lookupWrite,
  input  logic               lookupSuper,
  input  logic [TAG_W-1:0]   fillPage,
  input  logic [FRAME_W-1:0] fillFrame,
  input  permBits_t          fillPerm,
  input  logic [TAG_W-1:0]   invPage,
  output logic [ENTRIES-1:0] validVec,
  output logic [ENTRIES-1:0] fillMatchVec,
  output logic               hit,
  output logic               miss,
  output logic               fault,
  output logic [FRAME_W-1:0] frameOut
);

  logic [ENTRIES-1:0] entValid;
  logic [TAG_W-1:0]   tagArr   [ENTRIES];
  logic [FRAME_W-1:0] frameArr [ENTRIES];
  permBits_t          permArr  [ENTRIES];

  logic [ENTRIES-1:0] lookMatch;
  logic [ENTRIES-1:0] invMatch;

  // Per-entry comparators: one for each port that searches by page
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lookMatch[i]    = entValid[i] && (tagArr[i] == lookupPage);
    assign fillMatchVec[i] = entValid[i] && (tagArr[i] == fillPage);
    assign invMatch[i]     = entValid[i] && (tagArr[i] == invPage);
  end

  assign validVec = entValid;

  // Valid bits: flush beats single drop beats fill
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entValid <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobe.flushAll)
          entValid[i] <= 1'b0;
        else if (strobe.dropOne && invMatch[i])
          entValid[i] <= 1'b0;
        else if (strobe.fillEn && wrSel[i])
          entValid[i] <= 1'b1;
      end
    end
  end

  // Payload storage needs no reset; valid bits guard it
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (strobe.fillEn && wrSel[i]) begin
        tagArr[i]   <= fillPage;
        frameArr[i] <= fillFrame;
        permArr[i]  <= fillPerm;
      end
    end
  end

  // At most one entry matches, so OR-merging selects it
  logic [FRAME_W-1:0] selFrame;
  permBits_t          selPerm;
  logic               anyMatch;
  logic               denied;

  always_comb begin
    selFrame = '0;
    selPerm  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookMatch[i]) begin
        selFrame = selFrame | frameArr[i];
        selPerm  = selPerm  | permArr[i];
      end
    end
    anyMatch = |lookMatch;
    denied   = (lookupWrite ? !selPerm.canWrite : !selPerm.canRead)
             || (selPerm.supOnly && !lookupSuper);
  end

  assign fault    = lookupValid && anyMatch && denied;
  assign hit      = lookupValid && anyMatch && !denied;
  assign miss     = lookupValid && !anyMatch;
  assign frameOut = hit ? selFrame : '0;

endmodule

// File: rtl/xcache_control.sv
`timescale 1ns/1ps
module xcache_control
  import xcache_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               invValid,
  input  logic               invAll,
  input  logic [ENTRIES-1:0] validVec,
  input  logic [ENTRIES-1:0] fillMatchVec,
  output ctrlStrobe_t        strobe,
  output logic [ENTRIES-1:0] wrSel
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);
  localparam logic [ENTRIES-1:0] ONE_HOT0 = ENTRIES'(1);

  logic [IDX_W-1:0]   victimPtr;
  logic [ENTRIES-1:0] freeVec;
  logic               useVictim;

  assign freeVec = ~validVec;

  function automatic logic [ENTRIES-1:0] lowestOne(input logic [ENTRIES-1:0] v);
    return v & (~v + ONE_HOT0);
  endfunction

  // Slot choice: same page, then lowest free, then victim
  always_comb begin
    strobe    = '0;
    wrSel     = '0;
    useVictim = 1'b0;
    if (invValid) begin
      strobe.flushAll = invAll;
      strobe.dropOne  = !invAll;
    end else if (fillValid) begin
      strobe.fillEn = 1'b1;
      if (|fillMatchVec) begin
        wrSel = lowestOne(fillMatchVec);
      end else if (|freeVec) begin
        wrSel = lowestOne(freeVec);
      end else begin
        wrSel     = ONE_HOT0 << victimPtr;
        useVictim = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      victimPtr <= '0;
    else if (useVictim)
      victimPtr <= (victimPtr == LAST_IDX) ? '0 : victimPtr + 1'b1;
  end

endmodule

// File: rtl/xcache_top.sv
`timescale 1ns/1ps
module xcache_top
  import xcache_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int TAG_W   = 20,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic [TAG_W-1:0]   lookupPage,
  input  logic               lookupWrite,
  input  logic               lookupSuper,
  output logic               hit,
  output logic               miss,
  output logic               fault,
  output logic [FRAME_W-1:0] frameOut,
  input  logic               fillValid,
  input  logic [TAG_W-1:0]   fillPage,
  input  logic [FRAME_W-1:0] fillFrame,
  input  logic               fillSupOnly,
  input  logic               fillCanRead,
  input  logic               fillCanWrite,
  input  logic               invValid,
  input  logic               invAll,
  input  logic [TAG_W-1:0]   invPage
);

  ctrlStrobe_t        strobe;
  logic [ENTRIES-1:0] wrSel;
  logic [ENTRIES-1:0] validVec;
  logic [ENTRIES-1:0] fillMatchVec;
  permBits_t          fillPerm;

  assign fillPerm = '{supOnly: fillSupOnly, canRead: fillCanRead, canWrite: fillCanWrite};

  xcache_control #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fillValid    (fillValid),
    .invValid     (invValid),
    .invAll       (invAll),
    .validVec     (validVec),
    .fillMatchVec (fillMatchVec),
    .strobe       (strobe),
    .wrSel        (wrSel)
  );

  xcache_datapath #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .FRAME_W(FRAME_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .wrSel        (wrSel),
    .lookupValid  (lookupValid),
    .lookupPage   (lookupPage),
    .lookupWrite  (lookupWrite),
    .lookupSuper  (lookupSuper),
    .fillPage     (fillPage),
    .fillFrame    (fillFrame),
    .fillPerm     (fillPerm),
    .invPage      (invPage),
    .validVec     (validVec),
    .fillMatchVec (fillMatchVec),
    .hit          (hit),
    .miss         (miss),
    .fault        (fault),
    .frameOut     (frameOut)
  );

endmodule

// File: rtl/xcache_checker.sv
`timescale 1ns/1ps
module xcache_checker #(
  parameter int TAG_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic [TAG_W-1:0] lookupPage,
  input logic             hit,
  input logic             miss,
  input logic             fault,
  input logic             fillValid,
  input logic [TAG_W-1:0] fillPage,
  input logic             invValid,
  input logic             invAll,
  input logic [TAG_W-1:0] invPage
);

  // R7
  result_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({hit, miss, fault}));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !(hit || miss || fault));

  // R12
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && invAll) |=> (lookupValid |-> (miss && !hit && !fault)));

  // R11
  drop_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (invValid && !invAll) |=> ((lookupValid && lookupPage == $past(invPage)) |-> miss));

  // R9
  fill_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && !invValid) |=> ((lookupValid && lookupPage == $past(fillPage)) |-> !miss));

  // R13
  fill_dropped_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fillValid && invValid && invAll) |=> ((lookupValid && lookupPage == $past(fillPage)) |-> miss));

endmodule

bind xcache_top xcache_checker #(.TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .lookupValid (lookupValid),
  .lookupPage  (lookupPage),
  .hit         (hit),
  .miss        (miss),
  .fault       (fault),
  .fillValid   (fillValid),
  .fillPage    (fillPage),
  .invValid    (invValid),
  .invAll      (invAll),
  .invPage     (invPage)
);

// File: tb/xcache_top_bench.sv
`timescale 1ns/1ps
module xcache_top_bench;

  localparam int TAG_W   = 20;
  localparam int FRAME_W = 20;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               lookupValid = 1'b0;
  logic [TAG_W-1:0]   lookupPage = '0;
  logic               lookupWrite = 1'b0;
  logic               lookupSuper = 1'b0;
  logic               hit, miss, fault;
  logic [FRAME_W-1:0] frameOut;
  logic               fillValid = 1'b0;
  logic [TAG_W-1:0]   fillPage = '0;
  logic [FRAME_W-1:0] fillFrame = '0;
  logic               fillSupOnly = 1'b0;
  logic               fillCanRead = 1'b0;
  logic               fillCanWrite = 1'b0;
  logic               invValid = 1'b0;
  logic               invAll = 1'b0;
  logic [TAG_W-1:0]   invPage = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  xcache_top u_xcache_top (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupPage(lookupPage),
    .lookupWrite(lookupWrite), .lookupSuper(lookupSuper),
    .hit(hit), .miss(miss), .fault(fault), .frameOut(frameOut),
    .fillValid(fillValid), .fillPage(fillPage), .fillFrame(fillFrame),
    .fillSupOnly(fillSupOnly), .fillCanRead(fillCanRead), .fillCanWrite(fillCanWrite),
    .invValid(invValid), .invAll(invAll), .invPage(invPage)
  );

  typedef struct {
    logic               eHit;
    logic               eMiss;
    logic               eFault;
    logic [FRAME_W-1:0] eFrame;
    string              req;
  } expItem_t;

  expItem_t expQ[$];

  // Driver tasks: drive just after a falling edge, release one cycle later
  task automatic lookupExp(input logic [TAG_W-1:0] page, input logic wr, input logic sup,
                           input logic eHit, input logic eMiss, input logic eFault,
                           input logic [FRAME_W-1:0] eFrame, input string req);
    expItem_t it;
    @(negedge clk);
    lookupValid = 1'b1; lookupPage = page; lookupWrite = wr; lookupSuper = sup;
    it.eHit = eHit; it.eMiss = eMiss; it.eFault = eFault; it.eFrame = eFrame; it.req = req;
    expQ.push_back(it);
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic expectHit(input logic [TAG_W-1:0] page, input logic wr, input logic sup,
                           input logic [FRAME_W-1:0] frm, input string req);
    lookupExp(page, wr, sup, 1'b1, 1'b0, 1'b0, frm, req);
  endtask

  task automatic expectMiss(input logic [TAG_W-1:0] page, input string req);
    lookupExp(page, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0, req);
  endtask

  task automatic expectFault(input logic [TAG_W-1:0] page, input logic wr, input logic sup,
                             input string req);
    lookupExp(page, wr, sup, 1'b0, 1'b0, 1'b1, '0, req);
  endtask

  task automatic doFill(input logic [TAG_W-1:0] page, input logic [FRAME_W-1:0] frm,
                        input logic sOnly, input logic rd, input logic wr);
    @(negedge clk);
    fillValid = 1'b1; fillPage = page; fillFrame = frm;
    fillSupOnly = sOnly; fillCanRead = rd; fillCanWrite = wr;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doInv(input logic all, input logic [TAG_W-1:0] page);
    @(negedge clk);
    invValid = 1'b1; invAll = all; invPage = page;
    @(negedge clk);
    invValid = 1'b0;
  endtask

  task automatic doFlushWithFill(input logic [TAG_W-1:0] page, input logic [FRAME_W-1:0] frm);
    @(negedge clk);
    invValid = 1'b1; invAll = 1'b1;
    fillValid = 1'b1; fillPage = page; fillFrame = frm;
    fillSupOnly = 1'b0; fillCanRead = 1'b1; fillCanWrite = 1'b1;
    @(negedge clk);
    invValid = 1'b0; fillValid = 1'b0;
  endtask

  // Monitor: samples mid low phase, away from the rising edge
  always begin
    @(negedge clk);
    #1;
    if (rstN && !finished) begin
      if (lookupValid) begin
        if (expQ.size() == 0) begin
          checks++; fails++;
          $display("FAIL scoreboard: result with no expected item, actual hit=%0b miss=%0b fault=%0b expected none",
                   hit, miss, fault);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          checks++;
          if (hit !== it.eHit || miss !== it.eMiss || fault !== it.eFault || frameOut !== it.eFrame) begin
            fails++;
            $display("FAIL %s page=%h: actual hit=%0b miss=%0b fault=%0b frame=%h expected hit=%0b miss=%0b fault=%0b frame=%h",
                     it.req, lookupPage, hit, miss, fault, frameOut,
                     it.eHit, it.eMiss, it.eFault, it.eFrame);
          end
        end
      end else begin
        checks++;
        if (hit || miss || fault) begin // R7 idle outputs
          fails++;
          $display("FAIL R7 idle: actual hit=%0b miss=%0b fault=%0b expected all 0", hit, miss, fault);
        end
      end
    end
  end

  task automatic finishRun();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual run still busy expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: empty after reset
    expectMiss(20'h00005, "R1");
    expectMiss(20'h00000, "R1");

    // R2: read and write hit on a fully permitted user page
    doFill(20'h00010, 20'hABCDE, 1'b0, 1'b1, 1'b1);
    expectHit(20'h00010, 1'b0, 1'b0, 20'hABCDE, "R2");
    expectHit(20'h00010, 1'b1, 1'b0, 20'hABCDE, "R2");

    // R4: write to read-only page faults, read hits
    doFill(20'h00020, 20'h11111, 1'b0, 1'b1, 1'b0);
    expectHit(20'h00020, 1'b0, 1'b0, 20'h11111, "R4");
    expectFault(20'h00020, 1'b1, 1'b0, "R4");
    expectFault(20'h00020, 1'b1, 1'b1, "R4");

    // R5: read of non-readable page faults, write hits
    doFill(20'h00030, 20'h33333, 1'b0, 1'b0, 1'b1);
    expectFault(20'h00030, 1'b0, 1'b0, "R5");
    expectHit(20'h00030, 1'b1, 1'b0, 20'h33333, "R5");

    // R6: supervisor-only page
    doFill(20'h00040, 20'h44444, 1'b1, 1'b1, 1'b1);
    expectFault(20'h00040, 1'b0, 1'b0, "R6");
    expectFault(20'h00040, 1'b1, 1'b0, "R6");
    expectHit(20'h00040, 1'b0, 1'b1, 20'h44444, "R6");

    // R3: unknown page misses with zero frame
    expectMiss(20'h00099, "R3");
    expectMiss(20'hFFFFF, "R3");

    // R8: refill same page replaces, no stale duplicate
    doFill(20'h00020, 20'h22222, 1'b0, 1'b1, 1'b1);
    expectHit(20'h00020, 1'b1, 1'b0, 20'h22222, "R8");
    doInv(1'b0, 20'h00020);
    expectMiss(20'h00020, "R8");

    // R11: only the named page left
    expectHit(20'h00010, 1'b0, 1'b0, 20'hABCDE, "R11");
    expectHit(20'h00030, 1'b1, 1'b0, 20'h33333, "R11");

    // R12: flush clears everything
    doInv(1'b1, '0);
    expectMiss(20'h00010, "R12");
    expectMiss(20'h00040, "R12");

    // R9/R10: fill slots 0..7, free slot 3, then replace
    for (int i = 0; i < 8; i++)
      doFill(20'h00100 + TAG_W'(i), 20'h00500 + FRAME_W'(i), 1'b0, 1'b1, 1'b1);
    doInv(1'b0, 20'h00103);
    doFill(20'h00200, 20'h00600, 1'b0, 1'b1, 1'b1); // slot 3 (free)
    doFill(20'h00201, 20'h00601, 1'b0, 1'b1, 1'b1); // victim 0
    doFill(20'h00202, 20'h00602, 1'b0, 1'b1, 1'b1); // victim 1
    expectMiss(20'h00100, "R10");
    expectMiss(20'h00101, "R10");
    expectHit(20'h00102, 1'b0, 1'b0, 20'h00502, "R9");
    expectHit(20'h00104, 1'b0, 1'b0, 20'h00504, "R9");
    expectHit(20'h00107, 1'b0, 1'b0, 20'h00507, "R9");
    expectHit(20'h00200, 1'b0, 1'b0, 20'h00600, "R9");
    expectHit(20'h00201, 1'b0, 1'b0, 20'h00601, "R10");
    expectHit(20'h00202, 1'b0, 1'b0, 20'h00602, "R10");

    // R10: walk pointer through slots 2..7, wrap to 0
    for (int i = 3; i < 9; i++)
      doFill(20'h00200 + TAG_W'(i), 20'h00600 + FRAME_W'(i), 1'b0, 1'b1, 1'b1);
    expectMiss(20'h00102, "R10");
    expectMiss(20'h00200, "R10");
    expectHit(20'h00201, 1'b0, 1'b0, 20'h00601, "R10");
    doFill(20'h00209, 20'h00609, 1'b0, 1'b1, 1'b1); // wrapped to slot 0
    expectMiss(20'h00201, "R10");
    expectHit(20'h00202, 1'b0, 1'b0, 20'h00602, "R10");
    expectHit(20'h00209, 1'b1, 1'b0, 20'h00609, "R10");

    // R13: fill colliding with flush is dropped
    doFlushWithFill(20'h00300, 20'h00700);
    expectMiss(20'h00300, "R13");
    expectMiss(20'h00202, "R13");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: actual %0d items left expected 0", expQ.size());
    end
    finishRun();
  end

endmodule